// File: doc/BRIEF.md
# Extended Parallel-Port Control Window with FIFO Loopback

This block implements the upper register window of an extended-capability parallel port. The window sits at a fixed distance above the port's base address. It holds a mode/control register, a second configuration register and a two-entry byte FIFO. Host software reaches them through byte accesses on a 3-bit offset. The mode/control register chooses one of eight port modes. Its low two bits always report whether the FIFO is empty, full or partly filled.

The FIFO is reachable from the host only in the loopback-test mode, where software checks the queue by writing bytes to offset 0 and reading them back. In every other mode, offset 0 is an ordinary storage byte. In the configuration mode, a read of offset 0 returns a fixed descriptor that reports the FIFO word width. Any write that changes the mode discards whatever the FIFO holds. Transfers to the physical port pins are not part of this block.

Reads are combinational: `host_rdata` shows the addressed register during the cycle in which `host_rd` is high. Any side effect of the access, such as a pop, takes place at the clock edge that ends that cycle. If `host_wr` and `host_rd` are both high, the access counts as a write only.

Top module: `ecpx_window`

## Requirements
- R1: After reset, offset 2 reads 0x01 (mode 0 with the FIFO empty), and offsets 0 and 1 read 0x00.
- R2: A write to offset 2 replaces bits 7:5 (mode) and bits 4:2 with the written value. Bits 1:0 ignore the written value.
- R3: Bits 1:0 of offset 2 read 01 when the FIFO is empty, 10 when it is full, and 00 when it holds one byte. The value 11 never appears.
- R4: In mode 6 (loopback test), a write to offset 0 pushes the byte and a read of offset 0 pops the oldest byte. Bytes come out in first-in first-out order, including after the pointers wrap.
- R5: In mode 6, a push while the FIFO holds two bytes is dropped, and the stored bytes are left unchanged.
- R6: In mode 6, a read of offset 0 while the FIFO is empty returns the last byte popped, or 0x00 if no byte has been popped since reset. The FIFO stays empty.
- R7: A write to offset 2 whose bits 7:5 differ from the current mode empties the FIFO. A write to offset 2 that keeps the same mode leaves the FIFO contents unchanged.
- R8: In every mode other than 6, a write to offset 0 stores the byte in a plain register and does not touch the FIFO. In modes 0 to 5, offset 0 reads back that byte.
- R9: In mode 7 (configuration), a read of offset 0 returns 0x10, which reports an 8-bit FIFO word in bits 6:4 (code 001). A write to offset 0 in this mode still updates the plain register.
- R10: Offset 1 is a read/write byte register.
- R11: Offsets 3 to 7 read 0x00, and writes to them change no other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe for one cycle |
| host_rd | input | 1 | Read strobe for one cycle; a pop takes effect at the closing edge |
| host_off | input | 3 | Register offset within the window |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data for the addressed offset |

## Verification
The bound checker runs on every cycle and covers these properties:
- The status code is never 11.
- Every write to offset 2 loads the mode field.
- A change of mode leaves the FIFO empty.
- A push into a full FIFO and a pop from an empty FIFO do not change the occupancy.
- A write to offset 0 outside mode 6 never touches the FIFO.
- Offset 1 captures the written byte.

Some behaviours can only be shown by the bench's scenarios, because they depend on the bytes in flight:
- First-in first-out order across the pointer wrap.
- Repetition of the last popped byte when the FIFO is empty.
- Loss of queued data on a mode change but not on a write that keeps the mode.
- The configuration descriptor.
- Survival of the plain register across loopback traffic.

// File: rtl/ecpx_pkg.sv
package ecpx_pkg;

    typedef enum logic [2:0] {
        MODE_COMPAT  = 3'd0,
        MODE_BYTE    = 3'd1,
        MODE_PPFIFO  = 3'd2,
        MODE_ECPFIFO = 3'd3,
        MODE_EPP     = 3'd4,
        MODE_RSVD    = 3'd5,
        MODE_TEST    = 3'd6,
        MODE_CFG     = 3'd7
    } ecpx_mode_e;

    // status codes in the two low bits of the mode/control register
    localparam logic [1:0] STAT_PART  = 2'b00;
    localparam logic [1:0] STAT_EMPTY = 2'b01;
    localparam logic [1:0] STAT_FULL  = 2'b10;

    // word-width code reported by the configuration descriptor
    localparam logic [2:0] WCODE_8BIT = 3'b001;

    localparam logic [2:0] OFF_DATA = 3'd0;
    localparam logic [2:0] OFF_CFGB = 3'd1;
    localparam logic [2:0] OFF_MCTL = 3'd2;

endpackage

// File: rtl/ecpx_fifo.sv
module ecpx_fifo #(
    parameter int DEPTH = 2,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic [DW-1:0]            last;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign dout  = empty ? st_q.last : st_q.mem[st_q.rp];

    always_comb begin
        logic do_push;
        logic do_pop;
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp           = bump(st_q.wp);
            end
            if (do_pop) begin
                st_d.last = st_q.mem[st_q.rp];
                st_d.rp   = bump(st_q.rp);
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ecpx_ctrl.sv
module ecpx_ctrl
    import ecpx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [2:0]    host_off,
    input  logic [DW-1:0] host_wdata,
    output ecpx_mode_e    mode,
    output logic [2:0]    mid_bits,
    output logic [DW-1:0] cfgb,
    output logic [DW-1:0] plain,
    output logic          fifo_push,
    output logic          fifo_pop,
    output logic          fifo_flush
);
    typedef struct packed {
        ecpx_mode_e    mode;
        logic [2:0]    mid;
        logic [DW-1:0] cfgb;
        logic [DW-1:0] plain;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     in_test;
    logic     rd_only;

    assign in_test = (st_q.mode == MODE_TEST);
    assign rd_only = host_rd && !host_wr;

    always_comb begin
        st_d       = st_q;
        fifo_push  = 1'b0;
        fifo_pop   = 1'b0;
        fifo_flush = 1'b0;
        if (host_wr) begin
            case (host_off)
                OFF_DATA: begin
                    if (in_test) fifo_push = 1'b1;
                    else         st_d.plain = host_wdata;
                end
                OFF_CFGB: st_d.cfgb = host_wdata;
                OFF_MCTL: begin
                    st_d.mode  = ecpx_mode_e'(host_wdata[7:5]);
                    st_d.mid   = host_wdata[4:2];
                    fifo_flush = (host_wdata[7:5] != st_q.mode);
                end
                default: ;
            endcase
        end else if (rd_only && host_off == OFF_DATA && in_test) begin
            fifo_pop = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_COMPAT, mid: '0, cfgb: '0, plain: '0};
        else        st_q <= st_d;
    end

    assign mode     = st_q.mode;
    assign mid_bits = st_q.mid;
    assign cfgb     = st_q.cfgb;
    assign plain    = st_q.plain;

endmodule

// File: rtl/ecpx_rdmux.sv
module ecpx_rdmux
    import ecpx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [2:0]    host_off,
    input  ecpx_mode_e    mode,
    input  logic [2:0]    mid_bits,
    input  logic [DW-1:0] cfgb,
    input  logic [DW-1:0] plain,
    input  logic [DW-1:0] fifo_dout,
    input  logic          fifo_empty,
    input  logic          fifo_full,
    output logic [DW-1:0] rdata
);
    logic [1:0]    stat_code;
    logic [DW-1:0] descr;

    assign descr = DW'({1'b0, WCODE_8BIT, 4'b0000});

    always_comb begin
        if (fifo_empty)     stat_code = STAT_EMPTY;
        else if (fifo_full) stat_code = STAT_FULL;
        else                stat_code = STAT_PART;
    end

    always_comb begin
        rdata = '0;
        case (host_off)
            OFF_DATA: begin
                if (mode == MODE_TEST)     rdata = fifo_dout;
                else if (mode == MODE_CFG) rdata = descr;
                else                       rdata = plain;
            end
            OFF_CFGB: rdata = cfgb;
            OFF_MCTL: rdata = DW'({mode, mid_bits, stat_code});
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecpx_window.sv
module ecpx_window
    import ecpx_pkg::*;
#(
    parameter int FIFO_DEPTH = 2,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_off,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    ecpx_mode_e        ecr_mode;
    logic [2:0]        ecr_mid;
    logic [DATA_W-1:0] cfgb_val;
    logic [DATA_W-1:0] plain_val;
    logic [DATA_W-1:0] fifo_dout;
    logic              fifo_push;
    logic              fifo_pop;
    logic              fifo_flush;
    logic              fifo_empty;
    logic              fifo_full;

    ecpx_ctrl #(.DW(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_off   (host_off),
        .host_wdata (host_wdata),
        .mode       (ecr_mode),
        .mid_bits   (ecr_mid),
        .cfgb       (cfgb_val),
        .plain      (plain_val),
        .fifo_push  (fifo_push),
        .fifo_pop   (fifo_pop),
        .fifo_flush (fifo_flush)
    );

    ecpx_fifo #(.DEPTH(FIFO_DEPTH), .DW(DATA_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .flush (fifo_flush),
        .din   (host_wdata),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    ecpx_rdmux #(.DW(DATA_W)) u_rdmux (
        .host_off   (host_off),
        .mode       (ecr_mode),
        .mid_bits   (ecr_mid),
        .cfgb       (cfgb_val),
        .plain      (plain_val),
        .fifo_dout  (fifo_dout),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .rdata      (host_rdata)
    );

endmodule

// File: rtl/ecpx_window_chk.sv
module ecpx_window_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [2:0]        host_off,
    input logic [DATA_W-1:0] host_wdata,
    input logic [2:0]        mode,
    input logic [DATA_W-1:0] cfgb_val,
    input logic              fifo_empty,
    input logic              fifo_full
);
    p_status_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_off == 3'd2) |=> (mode == $past(host_wdata[7:5])));

    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_off == 3'd2 && host_wdata[7:5] != mode)
        |=> (fifo_empty && !fifo_full));

    p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6 && host_wr && host_off == 3'd0 && fifo_full) |=> fifo_full);

    p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6 && host_rd && !host_wr && host_off == 3'd0 && fifo_empty)
        |=> fifo_empty);

    p_plain_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd6 && host_wr && host_off == 3'd0)
        |=> ($stable(fifo_empty) && $stable(fifo_full)));

    p_cfgb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_off == 3'd1) |=> (cfgb_val == $past(host_wdata)));

endmodule

bind ecpx_window ecpx_window_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_off   (host_off),
    .host_wdata (host_wdata),
    .mode       (ecr_mode),
    .cfgb_val   (cfgb_val),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full)
);

// File: tb/ecpx_window_tb.sv
`timescale 1ns/1ps
module ecpx_window_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [2:0] host_off = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    ecpx_window u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_off   (host_off),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic put_wr(input logic [2:0] off, input logic [7:0] val);
        @(posedge clk); #1;
        host_wr = 1'b1; host_rd = 1'b0; host_off = off; host_wdata = val;
    endtask

    task automatic put_rd(input logic [2:0] off, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        host_wr = 1'b0; host_rd = 1'b1; host_off = off; host_wdata = '0;
    endtask

    task automatic put_idle();
        @(posedge clk); #1;
        host_wr = 1'b0; host_rd = 1'b0; host_off = '0; host_wdata = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: compares each read against the scoreboard, mid-cycle
    always @(negedge clk) begin
        if (rst_n && host_rd) begin
            logic [7:0] e;
            string      t;
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read: actual %02h expected none", host_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (host_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", t, host_rdata, e);
                end
            end
        end
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values
        put_rd(3'd2, 8'h01, "R1 mctl reset");
        put_rd(3'd1, 8'h00, "R1 cfgb reset");
        put_rd(3'd0, 8'h00, "R1 data reset");
        // R10 configuration byte
        put_wr(3'd1, 8'hA5);
        put_rd(3'd1, 8'hA5, "R10 cfgb readback");
        // R11 unused offsets
        put_wr(3'd5, 8'h77);
        put_wr(3'd3, 8'hFF);
        put_rd(3'd5, 8'h00, "R11 off5");
        put_rd(3'd3, 8'h00, "R11 off3");
        put_rd(3'd7, 8'h00, "R11 off7");
        put_rd(3'd1, 8'hA5, "R11 cfgb untouched");
        put_rd(3'd2, 8'h01, "R11 mctl untouched");
        // R8 plain register in mode 0
        put_wr(3'd0, 8'h3C);
        put_rd(3'd0, 8'h3C, "R8 plain mode0");
        put_rd(3'd2, 8'h01, "R8 fifo untouched");
        // R2 mode field replaced, low bits ignored
        put_wr(3'd2, 8'h2B);
        put_rd(3'd2, 8'h29, "R2 mode1 mid2 status");
        put_rd(3'd0, 8'h3C, "R8 plain mode1");
        // enter loopback mode
        put_wr(3'd2, 8'hC0);
        put_rd(3'd2, 8'hC1, "R2 mode6 empty");
        // R4 / R3 push and status
        put_wr(3'd0, 8'h11);
        put_rd(3'd2, 8'hC0, "R3 one byte");
        put_wr(3'd0, 8'h22);
        put_rd(3'd2, 8'hC2, "R3 full");
        // R5 overflow dropped
        put_wr(3'd0, 8'h33);
        put_rd(3'd2, 8'hC2, "R5 still full");
        put_rd(3'd0, 8'h11, "R4 pop first");
        put_rd(3'd2, 8'hC0, "R3 partial after pop");
        put_rd(3'd0, 8'h22, "R5 second kept, third dropped");
        put_rd(3'd2, 8'hC1, "R3 empty after pops");
        // R6 underflow repeats last byte
        put_rd(3'd0, 8'h22, "R6 empty pop repeats");
        put_rd(3'd2, 8'hC1, "R6 stays empty");
        // R4 wrap-around ordering
        put_wr(3'd0, 8'h44);
        put_wr(3'd0, 8'h55);
        put_rd(3'd0, 8'h44, "R4 wrap first");
        put_wr(3'd0, 8'h66);
        put_rd(3'd0, 8'h55, "R4 wrap second");
        put_rd(3'd0, 8'h66, "R4 wrap third");
        put_rd(3'd2, 8'hC1, "R4 drained");
        // R7 same-mode write keeps contents
        put_wr(3'd0, 8'h77);
        put_wr(3'd2, 8'hC4);
        put_rd(3'd2, 8'hC4, "R7 same mode keeps data");
        put_rd(3'd0, 8'h77, "R7 data survives");
        // R7 mode change flushes
        put_wr(3'd0, 8'h88);
        put_wr(3'd2, 8'h00);
        put_rd(3'd2, 8'h01, "R7 flushed on change");
        put_rd(3'd0, 8'h3C, "R8 plain survives loopback traffic");
        put_wr(3'd2, 8'hC0);
        put_rd(3'd0, 8'h77, "R7 queued byte discarded");
        put_rd(3'd2, 8'hC1, "R7 still empty");
        // R9 configuration descriptor
        put_wr(3'd2, 8'hE0);
        put_rd(3'd0, 8'h10, "R9 descriptor");
        put_wr(3'd0, 8'h5A);
        put_rd(3'd0, 8'h10, "R9 descriptor after write");
        put_wr(3'd2, 8'h40);
        put_rd(3'd0, 8'h5A, "R9 write in cfg mode stored");
        put_rd(3'd2, 8'h41, "R2 mode2 readback");
        put_idle();
        put_idle();
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule